// File: doc/BRIEF.md
# Package Low-Power State Controller

This block steps a processor package through its idle levels. The levels are run, a clock-stopped sleep level, a deep sleep level with the reference clock off, and a deeper level at reduced core voltage. The core gives a two-bit package request and a performance-point request. A break event pulls the package back toward run. The controller drives three active-low strobes, one for each idle level. It also drives a 7-bit voltage-ID code and a request/done handshake to an external performance stepper, which moves the package between operating points.

An idle request can be marked extended, either by a per-request hint or by a configuration bit that promotes every request. When an extended request arrives, the controller first steps the package down to operating point 0, the lowest, and saves the point it left. Only after that does it enter the idle level. On the way out, run resumes at once and the step back up to the saved point follows. In hard mode, an extended episode that reached the deeper level ends at the lowest point and no step up is made. After the deep sleep strobe releases, a watchdog checks that the reference clock returns in time.

Top module: `pkg_lowpower_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all three strobes are high, `core_run` is 1, `step_req` is 0, `clk_late` is 0, `perf_cur` equals RESET_PERF (5), and `vid` equals VID_BASE + 4·`perf_cur` (VID_BASE = 16).
- R2: The `lp_req` encoding is 0 for run, 1 for sleep, 2 for deep sleep and 3 for deeper. From run, each clock moves one level deeper until the requested level is reached. `sleep_n` falls first, then `dsleep_n`, then `dstop_n`.
- R3: `dstop_n` falls only in a cycle that directly follows a cycle with `dsleep_n` low.
- R4: While `dstop_n` is low, `vid` equals `cfg_deeper_vid`. At every other time, `vid` equals 16 + 4·`perf_cur`.
- R5: The deeper level is left for deep sleep as soon as `lp_req` is not 3 or `perf_req` is not 0.
- R6: A break event, or a request for a shallower level, raises one strobe per clock. The order is `dstop_n`, then `dsleep_n`, then `sleep_n`. While `brk_evt` is high, no new entry starts from run.
- R7: On an extended request with `perf_cur` ≠ 0, the block raises `step_req` with `step_tgt` = 0 and holds it until `step_done`. `sleep_n` stays high until that handshake ends. The low-power level is entered with `perf_cur` = 0.
- R8: A request is extended when `ext_hint` or `cfg_auto_ext` is 1. When both are 0, the sleep level is entered on the next clock with no step.
- R9: When an extended episode ends outside hard mode, `core_run` rises on the same clock that `sleep_n` rises. `step_req` is then raised with `step_tgt` equal to the saved point. On `step_done`, `perf_cur` and `vid` return to their values from before the downshift.
- R10: When `cfg_hard_c4e` = 1 and an extended episode reached the deeper level, the exit ends in run with `perf_cur` = 0 and no step request.
- R11: While `sleep_n` is low, `step_req` is 0 and `perf_cur` is unchanged, even if `step_done` pulses.
- R12: After `dsleep_n` rises, `refclk_ok` must be seen high within CLK_WAIT (10) clocks. If it is not, `clk_late` pulses high for exactly one cycle, right after the 10th clock edge following the rise. If it is seen at that 10th edge, there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 2 | Requested package level (0 run, 1 sleep, 2 deep, 3 deeper) |
| ext_hint | input | 1 | Marks the current request as extended |
| cfg_auto_ext | input | 1 | Promotes every request to extended |
| cfg_hard_c4e | input | 1 | Hard mode: extended deeper exit stays at lowest point |
| cfg_deeper_vid | input | 7 | Voltage code driven in the deeper level |
| perf_req | input | PW | Core's requested performance point |
| brk_evt | input | 1 | Break event |
| step_done | input | 1 | Stepper finished the requested transition |
| refclk_ok | input | 1 | Reference clock is toggling |
| sleep_n | output | 1 | Sleep strobe, active low |
| dsleep_n | output | 1 | Deep sleep strobe, active low |
| dstop_n | output | 1 | Deeper stop strobe, active low |
| vid | output | 7 | Voltage-ID code |
| step_req | output | 1 | Request to the performance stepper |
| step_tgt | output | PW | Target point of the stepper request |
| perf_cur | output | PW | Current operating point |
| core_run | output | 1 | Control is with the core |
| clk_late | output | 1 | One-cycle flag: reference clock missed its window |

## Verification
Two actions can coincide in one cycle. The first is the end of an extended episode, where `sleep_n` rises. The second is the start of the step back up to the saved point, where `core_run` rises and `step_req` is raised. The bench provokes this by asserting `brk_evt` while in the extended sleep level. On the sample after that single edge, it requires `sleep_n`, `core_run` and `step_req` to be high together, with `step_tgt` equal to the point saved before the downshift. A second overlap is at the clock watchdog boundary. There, `refclk_ok` is raised exactly at the tenth edge, and the bench requires that no violation pulse appears.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_DOWN,
    ST_SLEEP,
    ST_DSLEEP,
    ST_DEEPER,
    ST_SHIFT
  } lp_state_t;

  localparam logic [1:0] REQ_RUN    = 2'd0;
  localparam logic [1:0] REQ_SLEEP  = 2'd1;
  localparam logic [1:0] REQ_DEEP   = 2'd2;
  localparam logic [1:0] REQ_DEEPER = 2'd3;

  // Voltage code of an operating point: linear in the point index.
  function automatic logic [6:0] lp_vid_of(input int unsigned pt,
                                           input int unsigned base,
                                           input int unsigned stp);
    int unsigned v;
    v = base + pt * stp;
    return v[6:0];
  endfunction

  // Depth of the package level (0 run .. 3 deeper) for strobe decoding.
  function automatic int unsigned lp_depth(input lp_state_t s);
    case (s)
      ST_SLEEP:  return 1;
      ST_DSLEEP: return 2;
      ST_DEEPER: return 3;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    lp_req,
  input  logic          ext_hint,
  input  logic          cfg_auto_ext,
  input  logic          cfg_hard_c4e,
  input  logic [PW-1:0] perf_req,
  input  logic          brk_evt,
  input  logic          step_done,
  input  logic          perf_is_low,
  output lp_state_t     state,
  output logic          ev_save,
  output logic          ev_dsleep_exit,
  output logic          ext_active
);

  lp_state_t nxt;
  logic      hard_exit;
  logic      ext_wanted;
  logic      leave_idle;
  logic      want_deep;

  assign ext_wanted = ext_hint | cfg_auto_ext;
  assign want_deep  = (lp_req == REQ_DEEP) || (lp_req == REQ_DEEPER);

  always_comb begin
    nxt     = state;
    ev_save = 1'b0;
    case (state)
      ST_RUN: begin
        if (lp_req != REQ_RUN && !brk_evt) begin
          if (ext_wanted && !perf_is_low) begin
            nxt     = ST_DOWN;
            ev_save = 1'b1;
          end else begin
            nxt = ST_SLEEP;
          end
        end
      end
      ST_DOWN:   if (step_done) nxt = ST_SLEEP;
      ST_SLEEP: begin
        if (brk_evt || lp_req == REQ_RUN)
          nxt = (ext_active && !hard_exit) ? ST_SHIFT : ST_RUN;
        else if (want_deep)
          nxt = ST_DSLEEP;
      end
      ST_DSLEEP: begin
        if (brk_evt || !want_deep)
          nxt = ST_SLEEP;
        else if (lp_req == REQ_DEEPER)
          nxt = ST_DEEPER;
      end
      ST_DEEPER: begin
        if (brk_evt || lp_req != REQ_DEEPER || perf_req != '0)
          nxt = ST_DSLEEP;
      end
      ST_SHIFT:  if (step_done) nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  assign ev_dsleep_exit = (state == ST_DSLEEP) && (nxt == ST_SLEEP);
  assign leave_idle     = (state == ST_SLEEP) && (nxt == ST_RUN || nxt == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      ext_active <= 1'b0;
      hard_exit  <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_save)
        ext_active <= 1'b1;
      else if (leave_idle)
        ext_active <= 1'b0;
      if (leave_idle)
        hard_exit <= 1'b0;
      else if (nxt == ST_DEEPER && ext_active && cfg_hard_c4e)
        hard_exit <= 1'b1;
    end
  end

  // R3
  deeper_from_deep_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEPER && $past(state) != ST_DEEPER) |-> $past(state) == ST_DSLEEP);

  // R6
  one_level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state) && $past(state) != ST_DOWN && $past(state) != ST_SHIFT
     && state != ST_DOWN && state != ST_SHIFT)
    |-> (lp_depth(state) + 1 == lp_depth($past(state)) ||
         lp_depth(state) == lp_depth($past(state)) + 1));

endmodule

// File: rtl/lp_perf_track.sv
module lp_perf_track
  import lp_pkg::*;
#(
  parameter int PW         = 3,
  parameter int RESET_PERF = 5,
  parameter int VID_BASE   = 16,
  parameter int VID_STEP   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  lp_state_t     state,
  input  logic          ev_save,
  input  logic          step_done,
  input  logic [6:0]    cfg_deeper_vid,
  output logic [PW-1:0] perf_cur,
  output logic          perf_is_low,
  output logic          step_req,
  output logic [PW-1:0] step_tgt,
  output logic [6:0]    vid
);

  localparam logic [PW-1:0] LOWEST_PT = '0;
  localparam logic [PW-1:0] RESET_PT  = PW'(RESET_PERF);

  logic [PW-1:0] saved_perf;
  logic [6:0]    saved_vid;
  logic          step_fin;

  assign step_req    = (state == ST_DOWN) || (state == ST_SHIFT);
  assign step_tgt    = (state == ST_DOWN) ? LOWEST_PT : saved_perf;
  assign step_fin    = step_req && step_done;
  assign perf_is_low = (perf_cur == LOWEST_PT);

  always_ff @(posedge clk) begin
    if (rst) begin
      perf_cur   <= RESET_PT;
      saved_perf <= RESET_PT;
      saved_vid  <= lp_vid_of(RESET_PERF, VID_BASE, VID_STEP);
    end else begin
      if (ev_save) begin
        saved_perf <= perf_cur;
        saved_vid  <= lp_vid_of(int'(perf_cur), VID_BASE, VID_STEP);
      end
      if (step_fin)
        perf_cur <= step_tgt;
    end
  end

  assign vid = (state == ST_DEEPER) ? cfg_deeper_vid
                                    : lp_vid_of(int'(perf_cur), VID_BASE, VID_STEP);

  // R11
  idle_perf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_depth(state) != 0) |=> $stable(perf_cur));

  // R9
  restore_vid_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_SHIFT && state == ST_RUN) |-> vid == saved_vid);

endmodule

// File: rtl/lp_clk_watch.sv
module lp_clk_watch #(
  parameter int CLK_WAIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_dsleep_exit,
  input  logic refclk_ok,
  output logic clk_late
);

  localparam int CW = $clog2(CLK_WAIT + 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          expire;

  assign expire = armed && !refclk_ok && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      cnt      <= '0;
      clk_late <= 1'b0;
    end else begin
      clk_late <= expire;
      if (ev_dsleep_exit) begin
        armed <= 1'b1;
        cnt   <= CW'(CLK_WAIT);
      end else if (armed) begin
        if (refclk_ok || expire)
          armed <= 1'b0;
        else
          cnt <= cnt - CW'(1);
      end
    end
  end

  // R12
  late_single_chk: assert property (@(posedge clk) disable iff (rst)
    clk_late |=> !clk_late);

  // R12
  late_only_armed_chk: assert property (@(posedge clk) disable iff (rst)
    clk_late |-> $past(armed) && !$past(refclk_ok));

endmodule

// File: rtl/pkg_lowpower_ctrl.sv
module pkg_lowpower_ctrl
  import lp_pkg::*;
#(
  parameter int PW         = 3,
  parameter int RESET_PERF = 5,
  parameter int VID_BASE   = 16,
  parameter int VID_STEP   = 4,
  parameter int CLK_WAIT   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    lp_req,
  input  logic          ext_hint,
  input  logic          cfg_auto_ext,
  input  logic          cfg_hard_c4e,
  input  logic [6:0]    cfg_deeper_vid,
  input  logic [PW-1:0] perf_req,
  input  logic          brk_evt,
  input  logic          step_done,
  input  logic          refclk_ok,
  output logic          sleep_n,
  output logic          dsleep_n,
  output logic          dstop_n,
  output logic [6:0]    vid,
  output logic          step_req,
  output logic [PW-1:0] step_tgt,
  output logic [PW-1:0] perf_cur,
  output logic          core_run,
  output logic          clk_late
);

  lp_state_t state;
  logic      ev_save;
  logic      ev_dsleep_exit;
  logic      ext_active;
  logic      perf_is_low;

  lp_fsm #(.PW(PW)) fsm_i (
    .clk           (clk),
    .rst           (rst),
    .lp_req        (lp_req),
    .ext_hint      (ext_hint),
    .cfg_auto_ext  (cfg_auto_ext),
    .cfg_hard_c4e  (cfg_hard_c4e),
    .perf_req      (perf_req),
    .brk_evt       (brk_evt),
    .step_done     (step_done),
    .perf_is_low   (perf_is_low),
    .state         (state),
    .ev_save       (ev_save),
    .ev_dsleep_exit(ev_dsleep_exit),
    .ext_active    (ext_active)
  );

  lp_perf_track #(
    .PW(PW), .RESET_PERF(RESET_PERF), .VID_BASE(VID_BASE), .VID_STEP(VID_STEP)
  ) perf_i (
    .clk           (clk),
    .rst           (rst),
    .state         (state),
    .ev_save       (ev_save),
    .step_done     (step_done),
    .cfg_deeper_vid(cfg_deeper_vid),
    .perf_cur      (perf_cur),
    .perf_is_low   (perf_is_low),
    .step_req      (step_req),
    .step_tgt      (step_tgt),
    .vid           (vid)
  );

  lp_clk_watch #(.CLK_WAIT(CLK_WAIT)) watch_i (
    .clk           (clk),
    .rst           (rst),
    .ev_dsleep_exit(ev_dsleep_exit),
    .refclk_ok     (refclk_ok),
    .clk_late      (clk_late)
  );

  assign sleep_n  = !(lp_depth(state) >= 1);
  assign dsleep_n = !(lp_depth(state) >= 2);
  assign dstop_n  = !(lp_depth(state) >= 3);
  assign core_run = (state == ST_RUN) || (state == ST_SHIFT);

  // R3
  dstop_after_dsleep_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dstop_n) |-> $past(!dsleep_n));

  // R2
  dsleep_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dsleep_n) |-> $past(!sleep_n));

  // R4
  deeper_vid_chk: assert property (@(posedge clk) disable iff (rst)
    !dstop_n |-> vid == cfg_deeper_vid);

  // R6
  unwind_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dsleep_n) |-> !sleep_n && $past(dstop_n));

  // R7
  ext_low_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleep_n) && ext_active) |-> perf_cur == '0);

  // R11
  no_step_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |-> !step_req);

endmodule

// File: tb/pkg_lowpower_ctrl_tb_top.sv
module pkg_lowpower_ctrl_tb_top;

  localparam int PW = 3;
  localparam logic [6:0] DEEP_VID = 7'h05;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    lp_req;
  logic          ext_hint, cfg_auto_ext, cfg_hard_c4e;
  logic [6:0]    cfg_deeper_vid;
  logic [PW-1:0] perf_req;
  logic          brk_evt, step_done, refclk_ok;
  logic          sleep_n, dsleep_n, dstop_n;
  logic [6:0]    vid;
  logic          step_req;
  logic [PW-1:0] step_tgt, perf_cur;
  logic          core_run, clk_late;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pkg_lowpower_ctrl dut_i (
    .clk(clk), .rst(rst), .lp_req(lp_req), .ext_hint(ext_hint),
    .cfg_auto_ext(cfg_auto_ext), .cfg_hard_c4e(cfg_hard_c4e),
    .cfg_deeper_vid(cfg_deeper_vid), .perf_req(perf_req), .brk_evt(brk_evt),
    .step_done(step_done), .refclk_ok(refclk_ok), .sleep_n(sleep_n),
    .dsleep_n(dsleep_n), .dstop_n(dstop_n), .vid(vid), .step_req(step_req),
    .step_tgt(step_tgt), .perf_cur(perf_cur), .core_run(core_run),
    .clk_late(clk_late)
  );

  function automatic int exp_vid(input int pt);
    return 16 + pt * 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_depth(input string tag, input int dep);
    chk({tag, " sleep_n"},  32'(sleep_n),  32'(dep < 1));
    chk({tag, " dsleep_n"}, 32'(dsleep_n), 32'(dep < 2));
    chk({tag, " dstop_n"},  32'(dstop_n),  32'(dep < 3));
  endtask

  task automatic pulse_done();
    step_done = 1'b1;
    tick();
    step_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lp_req = 2'd0; ext_hint = 1'b0; cfg_auto_ext = 1'b0;
    cfg_hard_c4e = 1'b0; cfg_deeper_vid = DEEP_VID; perf_req = '0;
    brk_evt = 1'b0; step_done = 1'b0; refclk_ok = 1'b1;
    repeat (3) tick();
    // R1 during reset
    chk_depth("R1 in reset", 0);
    rst = 1'b0;
    tick();
    chk_depth("R1 after reset", 0);
    chk("R1 core_run", 32'(core_run), 1);
    chk("R1 step_req", 32'(step_req), 0);
    chk("R1 clk_late", 32'(clk_late), 0);
    chk("R1 perf_cur", 32'(perf_cur), 5);
    chk("R1 vid", 32'(vid), 32'(exp_vid(5)));

    // R2 / R6 sweep: every depth, both exit causes
    for (int d = 1; d <= 3; d++) begin
      for (int m = 0; m < 2; m++) begin
        lp_req = 2'(d);
        for (int k = 1; k <= 4; k++) begin
          int dep;
          tick();
          dep = (k < d) ? k : d;
          chk_depth("R2 entry", dep);
          chk("R4 vid", 32'(vid), (dep == 3) ? 32'(DEEP_VID) : 32'(exp_vid(5)));
        end
        if (m == 0) lp_req = 2'd0; else brk_evt = 1'b1;
        for (int k = 1; k <= d; k++) begin
          tick();
          chk_depth("R6 unwind", d - k);
          chk("R6 core_run", 32'(core_run), 32'((d - k) == 0));
          chk("R12 no late with clock", 32'(clk_late), 0);
        end
        if (m == 1) begin
          lp_req = 2'(d);
          tick();
          chk_depth("R6 break blocks entry", 0);
        end
        brk_evt = 1'b0; lp_req = 2'd0;
        tick();
      end
    end

    // R5 deeper exit on perf request and on shallower request
    lp_req = 2'd3;
    repeat (3) tick();
    chk_depth("R5 in deeper", 3);
    perf_req = 3'd2;
    tick();
    chk_depth("R5 perf exit", 2);
    chk("R4 vid after exit", 32'(vid), 32'(exp_vid(5)));
    perf_req = '0;
    tick();
    chk_depth("R3 re-entry from deep", 3);
    lp_req = 2'd2;
    tick();
    chk_depth("R5 req exit", 2);
    tick();
    chk_depth("R5 deep held", 2);
    lp_req = 2'd0;
    repeat (2) tick();

    // R8 plain request takes no step
    lp_req = 2'd1;
    tick();
    chk("R8 plain sleep", 32'(sleep_n), 0);
    chk("R8 no step", 32'(step_req), 0);
    chk("R8 perf kept", 32'(perf_cur), 5);
    lp_req = 2'd0;
    tick();

    // R7 / R9 / R11 extended, by hint then by auto-promotion
    for (int m = 0; m < 2; m++) begin
      if (m == 0) ext_hint = 1'b1; else cfg_auto_ext = 1'b1;
      lp_req = 2'd1;
      for (int k = 0; k < 3; k++) begin
        tick();
        chk("R7 step_req", 32'(step_req), 1);
        chk("R7 step_tgt", 32'(step_tgt), 0);
        chk("R7 sleep held off", 32'(sleep_n), 1);
        chk("R8 ext taken", 32'(core_run), 0);
      end
      pulse_done();
      chk("R7 sleep entered", 32'(sleep_n), 0);
      chk("R7 perf lowest", 32'(perf_cur), 0);
      chk("R4 vid lowest", 32'(vid), 32'(exp_vid(0)));
      chk("R11 no step in sleep", 32'(step_req), 0);
      pulse_done();
      chk("R11 perf unchanged", 32'(perf_cur), 0);
      ext_hint = 1'b0; cfg_auto_ext = 1'b0;
      brk_evt = 1'b1; lp_req = 2'd0;
      tick();
      brk_evt = 1'b0;
      chk("R9 sleep released", 32'(sleep_n), 1);
      chk("R9 core_run same edge", 32'(core_run), 1);
      chk("R9 step up", 32'(step_req), 1);
      chk("R9 step_tgt saved", 32'(step_tgt), 5);
      pulse_done();
      chk("R9 perf restored", 32'(perf_cur), 5);
      chk("R9 vid restored", 32'(vid), 32'(exp_vid(5)));
      chk("R9 step ended", 32'(step_req), 0);
    end

    // R12 clock watchdog: missed window, then arrival at the last edge
    for (int m = 0; m < 2; m++) begin
      lp_req = 2'd2;
      repeat (2) tick();
      refclk_ok = 1'b0;
      lp_req = 2'd0;
      tick();
      chk("R12 dsleep released", 32'(dsleep_n), 1);
      chk("R12 no early flag", 32'(clk_late), 0);
      for (int k = 1; k <= 9; k++) begin
        tick();
        chk("R12 inside window", 32'(clk_late), 0);
      end
      if (m == 1) refclk_ok = 1'b1;
      tick();
      chk("R12 window end", 32'(clk_late), 32'(m == 0));
      tick();
      chk("R12 single pulse", 32'(clk_late), 0);
      refclk_ok = 1'b1;
      tick();
    end

    // R10 hard mode through the deeper level
    cfg_hard_c4e = 1'b1; ext_hint = 1'b1; lp_req = 2'd3;
    tick();
    chk("R10 step down", 32'(step_req), 1);
    pulse_done();
    ext_hint = 1'b0;
    repeat (2) tick();
    chk_depth("R10 deeper", 3);
    chk("R4 deeper vid hard", 32'(vid), 32'(DEEP_VID));
    lp_req = 2'd0;
    repeat (3) tick();
    chk_depth("R10 unwound", 0);
    chk("R10 core_run", 32'(core_run), 1);
    chk("R10 no step up", 32'(step_req), 0);
    chk("R10 perf lowest", 32'(perf_cur), 0);
    chk("R10 vid lowest", 32'(vid), 32'(exp_vid(0)));
    tick();
    chk("R10 still no step", 32'(step_req), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule